// File: doc/BRIEF.md
# Programmable Baud Clock Generator

This block derives a sixteen-times-oversampling clock for a serial transmitter or receiver from one reference. Each reference advance steps a four-stage prescaler that divides by sixteen. The prescaled tick then drives a bank of modulus counters, one for each standard bit rate. A four-bit select code chooses which counter reaches the output. Two of the codes bypass the counters and pass an external line straight through instead. That line can carry a foreign rate, or a fixed level that stops the output ("zero baud"). The three low prescaler stages and the reference advance strobe are brought out, so neighbouring channels can build further rates from the same chain.

The reference advances in one of two ways, set by a mode input. In primary mode it advances on every cycle of `clk`. In auxiliary mode it advances on each synchronised rising edge of a slow auxiliary clock pin. When the mode drops to auxiliary, the first high level seen on the auxiliary pin clears the whole divider chain. That edge is used up by the clear and does not count as an advance. In primary mode the auxiliary pin must be held low, because a high level there keeps the chain in clear. A synchronous clear input does the same job under software or system control.

With a 2.4576 MHz reference in primary mode, code 1000 gives 153.6 kHz, which is 16 × 9600 baud.

Top module: `baud_clk_gen`

## Requirements
- R1: While `rst_n` is low, `pre_q` reads 0 and `rate_out` reads 0.
- R2: In primary mode (`mode_pri`=1), `raw_tick` is 1 on every cycle. `pre_q[2:0]` counts up by one modulo 8 on every cycle, so bit 2 has a period of 8 cycles with 4 cycles high.
- R3: For a rate code, `rate_out` has a period of 16·D reference advances. D is determined by the code: 0010→192, 0011→128, 0100→71, 0101→48, 0110→16, 0111→4, 1000→1, 1001→2, 1010→5, 1011→8, 1100→4, 1101→32, 1110→64, 1111→87.
- R4: For D ≥ 2 the output is high for 16·floor(D/2) advances of each period. For D = 1 it is high for 8 of the 16.
- R5: Codes 0000 and 0001 copy `ext_in` to `rate_out` with a delay of one `clk` cycle. A constant `ext_in` therefore holds `rate_out` constant.
- R6: When `pre_q[2]` is looped back into `ext_in` under code 0001, `rate_out` has a period of 8 cycles with 4 cycles high.
- R7: In auxiliary mode (`mode_pri`=0), the prescaler advances by one for each rising edge of `aux_clk`, after a two-flop synchroniser. It holds its value while the pin is still. With code 1000 and an `aux_clk` period of 4 cycles, `rate_out` has a period of 64 cycles with 32 cycles high.
- R8: After `mode_pri` falls, the first high level on `aux_clk` clears the prescaler to 0. That edge does not advance it. The next rising edge advances it to 1.
- R9: While `mode_pri`=1 and `aux_clk` is high, the prescaler stays at 0.
- R10: A one-cycle pulse on `srst` clears the prescaler to 0 on the next clock edge.
- R11: A new select code is adopted only on a prescaler wrap or a clear. Switching from a rate code to another rate code therefore produces no output pulse shorter than the new rate's half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| srst | input | 1 | Synchronous active-high clear of the divider chain |
| mode_pri | input | 1 | 1: advance every cycle; 0: advance on auxiliary clock edges |
| aux_clk | input | 1 | Auxiliary clock pin (asynchronous) |
| rate_sel | input | 4 | Rate select code |
| ext_in | input | 1 | External line routed to the output by codes 0000 and 0001 |
| raw_tick | output | 1 | Reference advance strobe |
| pre_q | output | 3 | Low three prescaler stages |
| rate_out | output | 1 | Selected 16x bit-rate clock |

## Verification
Every rate code is run from a fresh clear, and both the period and the high time of a full cycle are measured. The measurements separate a wrong modulus from a wrong split point. They also separate the three odd divisors from their even neighbours, and the single-stage 9600 path from the counter-based rates. The external path is tried with a static low, a static high and the looped-back prescaler tap. These cases tell pass-through apart from a stale divider output. Auxiliary mode is stepped one edge at a time, which shows the consumed clearing edge, the held count and normal counting as separate outcomes. A mid-period code switch measures the shortest interior pulse to expose runts.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

  localparam int unsigned SEL_W     = 4;
  localparam int unsigned NUM_CODES = 1 << SEL_W;

  // Prescaled periods per output period for each select code; 0 marks the
  // codes that route the external line instead of a counter.
  function automatic int unsigned code_divisor(input int unsigned code);
    case (code)
      2:       return 192;
      3:       return 128;
      4:       return 71;
      5:       return 48;
      6:       return 16;
      7:       return 4;
      8:       return 1;
      9:       return 2;
      10:      return 5;
      11:      return 8;
      12:      return 4;
      13:      return 32;
      14:      return 64;
      15:      return 87;
      default: return 0;
    endcase
  endfunction

  function automatic logic is_ext_code(input logic [SEL_W-1:0] code);
    return code_divisor(int'(code)) == 0;
  endfunction

endpackage

// File: rtl/bg_clock_front.sv
module bg_clock_front (
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  input  logic mode_pri,
  input  logic aux_pin,
  output logic ref_en,
  output logic chain_clr,
  output logic aux_lvl
);

  logic aux_m, aux_s, aux_d, mode_q, armed;
  logic armed_nx, init_fire;

  always_comb begin
    init_fire = !mode_pri && armed && aux_s;
    armed_nx  = armed;
    if (mode_pri)       armed_nx = 1'b0;
    else if (init_fire) armed_nx = 1'b0;
    else if (mode_q)    armed_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_m  <= 1'b0;
      aux_s  <= 1'b0;
      aux_d  <= 1'b0;
      mode_q <= 1'b1;
      armed  <= 1'b0;
    end else begin
      aux_m  <= aux_pin;
      aux_s  <= aux_m;
      aux_d  <= aux_s;
      mode_q <= mode_pri;
      armed  <= armed_nx;
    end
  end

  assign ref_en    = mode_pri | (aux_s & ~aux_d);
  assign chain_clr = srst | init_fire | (mode_pri & aux_s);
  assign aux_lvl   = aux_s;

endmodule

// File: rtl/bg_prescaler.sv
module bg_prescaler #(
  parameter int unsigned PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ref_en,
  output logic [PRE_W-1:0] cnt,
  output logic             pre_tick
);

  logic [PRE_W-1:0] cnt_nx;

  always_comb begin
    cnt_nx = cnt;
    if (clr)         cnt_nx = '0;
    else if (ref_en) cnt_nx = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end

  assign pre_tick = ref_en && !clr && (cnt == {PRE_W{1'b1}});

endmodule

// File: rtl/bg_rate_div.sv
module bg_rate_div #(
  parameter int unsigned DIV = 2,
  parameter int unsigned CW  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic pre_msb,
  output logic div_out
);

  localparam int unsigned HALF = DIV / 2;

  generate
    if (DIV <= 1) begin : g_direct
      logic unused_direct;
      assign unused_direct = ^{clk, rst_n, clr, tick};
      assign div_out = pre_msb;
    end else begin : g_count
      logic [CW-1:0] cnt, cnt_nx;
      logic          out_q, out_nx;
      logic          unused_msb;
      assign unused_msb = pre_msb;

      always_comb begin
        cnt_nx = cnt;
        out_nx = out_q;
        if (clr) begin
          cnt_nx = '0;
          out_nx = 1'b1;
        end else if (tick) begin
          cnt_nx = (cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1;
          out_nx = (cnt_nx < CW'(HALF));
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt   <= '0;
          out_q <= 1'b0;
        end else begin
          cnt   <= cnt_nx;
          out_q <= out_nx;
        end
      end

      assign div_out = out_q;
    end
  endgenerate

endmodule

// File: rtl/bg_out_select.sv
module bg_out_select
  import baudgen_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 tick,
  input  logic [SEL_W-1:0]     sel,
  input  logic                 ext_in,
  input  logic [NUM_CODES-1:0] div_bus,
  output logic [SEL_W-1:0]     sel_q,
  output logic                 z
);

  logic [SEL_W-1:0] sel_nx;
  logic             z_nx;

  always_comb begin
    sel_nx = (clr || tick) ? sel : sel_q;
    z_nx   = is_ext_code(sel_q) ? ext_in : div_bus[sel_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      z     <= 1'b0;
    end else begin
      sel_q <= sel_nx;
      z     <= z_nx;
    end
  end

endmodule

// File: rtl/baud_clk_gen.sv
module baud_clk_gen
  import baudgen_pkg::*;
#(
  parameter int unsigned PRE_W = 4,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             mode_pri,
  input  logic             aux_clk,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             ext_in,
  output logic             raw_tick,
  output logic [PRE_W-2:0] pre_q,
  output logic             rate_out
);

  logic                 rst_m, rst_s;
  logic                 ref_en, chain_clr, aux_lvl, pre_tick;
  logic [PRE_W-1:0]     pre_cnt;
  logic [NUM_CODES-1:0] div_bus;
  logic [SEL_W-1:0]     sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  bg_clock_front u_front (
    .clk(clk), .rst_n(rst_s), .srst(srst), .mode_pri(mode_pri),
    .aux_pin(aux_clk), .ref_en(ref_en), .chain_clr(chain_clr), .aux_lvl(aux_lvl)
  );

  bg_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_s), .clr(chain_clr), .ref_en(ref_en),
    .cnt(pre_cnt), .pre_tick(pre_tick)
  );

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_rate
    localparam int unsigned D = code_divisor(c);
    if (D == 0) begin : g_ext
      assign div_bus[c] = 1'b0;
    end else begin : g_div
      bg_rate_div #(.DIV(D), .CW(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_s), .clr(chain_clr), .tick(pre_tick),
        .pre_msb(pre_cnt[PRE_W-1]), .div_out(div_bus[c])
      );
    end
  end

  bg_out_select u_sel (
    .clk(clk), .rst_n(rst_s), .clr(chain_clr), .tick(pre_tick),
    .sel(rate_sel), .ext_in(ext_in), .div_bus(div_bus),
    .sel_q(sel_q), .z(rate_out)
  );

  assign raw_tick = ref_en;
  assign pre_q    = pre_cnt[PRE_W-2:0];

endmodule

// File: rtl/bg_checker.sv
module bg_checker #(
  parameter int unsigned PRE_W = 4,
  parameter int unsigned SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_pri,
  input logic             aux_lvl,
  input logic             ref_en,
  input logic             chain_clr,
  input logic             pre_tick,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [SEL_W-1:0] sel_q,
  input logic             ext_in,
  input logic             rate_out
);

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_en && !chain_clr) |=> pre_cnt == PRE_W'($past(pre_cnt) + 1'b1)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_en && !chain_clr) |=> $stable(pre_cnt)); // R7

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    chain_clr |=> pre_cnt == '0); // R10

  AST_AUX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pri && aux_lvl) |=> pre_cnt == '0); // R9

  AST_EXT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q < SEL_W'(2)) |=> rate_out == $past(ext_in)); // R5

  AST_SEL_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(pre_tick || chain_clr)); // R11

endmodule

bind baud_clk_gen bg_checker #(.PRE_W(PRE_W), .SEL_W(baudgen_pkg::SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_s), .mode_pri(mode_pri), .aux_lvl(aux_lvl),
  .ref_en(ref_en), .chain_clr(chain_clr), .pre_tick(pre_tick),
  .pre_cnt(pre_cnt), .sel_q(sel_q), .ext_in(ext_in), .rate_out(rate_out)
);

// File: tb/baud_clk_gen_tb.sv
module baud_clk_gen_tb;

  typedef struct {
    int    per;
    int    high;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       srst = 1'b0;
  logic       mode_pri = 1'b1;
  logic       aux_clk = 1'b0;
  logic [3:0] rate_sel = 4'b1000;
  logic       im_lvl = 1'b0;
  logic       loop_en = 1'b0;
  logic       aux_run = 1'b0;
  logic       ext_in;
  logic       raw_tick, rate_out;
  logic [2:0] pre_q;

  int   n_chk = 0, n_fail = 0, cyc = 0;
  exp_t sb_q[$];
  event go_ev, done_ev;

  assign ext_in = loop_en ? pre_q[2] : im_lvl;

  always #5 clk = ~clk;

  baud_clk_gen u_dut (
    .clk(clk), .rst_n(rst_n), .srst(srst), .mode_pri(mode_pri), .aux_clk(aux_clk),
    .rate_sel(rate_sel), .ext_in(ext_in), .raw_tick(raw_tick), .pre_q(pre_q),
    .rate_out(rate_out)
  );

  function automatic int div_of(input int code);
    case (code)
      2: return 192;  3: return 128; 4: return 71;  5: return 48;
      6: return 16;   7: return 4;   8: return 1;   9: return 2;
      10: return 5;   11: return 8;  12: return 4;  13: return 32;
      14: return 64;  15: return 87;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_clear();
    srst = 1'b1;
    @(negedge clk);
    srst = 1'b0;
  endtask

  // driver: push an expected item and let the monitor measure it
  task automatic expect_wave(input int per, input int high, input string req);
    exp_t e;
    e.per = per; e.high = high; e.req = req;
    sb_q.push_back(e);
    ->go_ev;
    @(done_ev);
  endtask

  // monitor: pop, measure one full output period, compare
  always begin
    exp_t e;
    int lo, hi;
    @(go_ev);
    e = sb_q.pop_front();
    while (rate_out !== 1'b1) @(negedge clk);
    while (rate_out !== 1'b0) @(negedge clk);
    lo = 0;
    while (rate_out === 1'b0) begin lo++; @(negedge clk); end
    hi = 0;
    while (rate_out === 1'b1) begin hi++; @(negedge clk); end
    chk(lo + hi == e.per, {e.req, " period"}, lo + hi, e.per);
    chk(hi == e.high, {e.req, " high time"}, hi, e.high);
    ->done_ev;
  end

  always begin
    @(negedge clk);
    if (aux_run) begin
      aux_clk = 1'b1; @(negedge clk); @(negedge clk);
      aux_clk = 1'b0; @(negedge clk);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int d, p, prev, run, min_run, seen;
    // R1 reset state
    wait_n(3);
    chk(pre_q == 3'd0, "R1 pre_q in reset", pre_q, 0);
    chk(rate_out == 1'b0, "R1 rate_out in reset", rate_out, 0);
    rst_n = 1'b1;

    // R2 prescaler counting in primary mode
    while (pre_q != 3'd1) @(negedge clk);
    for (int j = 0; j < 16; j++) begin
      chk(pre_q == 3'((1 + j) % 8), "R2 prescaler step", pre_q, (1 + j) % 8);
      @(negedge clk);
    end
    chk(raw_tick == 1'b1, "R2 raw_tick", raw_tick, 1);

    // R10 clear
    wait_n(3);
    pulse_clear();
    chk(pre_q == 3'd0, "R10 srst clears", pre_q, 0);

    // R3 R4 every rate code
    for (int c = 2; c < 16; c++) begin
      rate_sel = 4'(c);
      pulse_clear();
      d = div_of(c);
      expect_wave(16 * d, (d == 1) ? 8 : 16 * (d / 2), $sformatf("R3/R4 code %0d", c));
    end

    // R5 static external levels
    rate_sel = 4'b0000; im_lvl = 1'b0;
    pulse_clear();
    wait_n(4);
    chk(rate_out == 1'b0, "R5 zero baud low", rate_out, 0);
    im_lvl = 1'b1;
    @(negedge clk);
    chk(rate_out == 1'b1, "R5 pass-through delay", rate_out, 1);
    wait_n(40);
    chk(rate_out == 1'b1, "R5 zero baud high", rate_out, 1);

    // R6 loopback of prescaler tap
    rate_sel = 4'b0001; loop_en = 1'b1;
    pulse_clear();
    expect_wave(8, 4, "R6 loopback");
    loop_en = 1'b0;

    // R11 switch between rate codes without clear
    rate_sel = 4'b1111;
    pulse_clear();
    wait_n(301);
    rate_sel = 4'b1000;
    prev = rate_out; run = 0; min_run = 1000; seen = 0;
    for (int k = 0; k < 900; k++) begin
      @(negedge clk);
      if (rate_out != prev) begin
        if (seen) min_run = (run < min_run) ? run : min_run;
        seen = 1; run = 1; prev = rate_out;
      end else run++;
    end
    chk(min_run == 8, "R11 no runt pulse", min_run, 8);

    // R9 continuous clear in primary mode
    aux_clk = 1'b1;
    wait_n(4);
    for (int k = 0; k < 8; k++) begin
      chk(pre_q == 3'd0, "R9 held clear", pre_q, 0);
      @(negedge clk);
    end
    aux_clk = 1'b0;
    wait_n(4);

    // R7 R8 auxiliary mode
    mode_pri = 1'b0;
    wait_n(6);
    p = pre_q;
    wait_n(6);
    chk(pre_q == 3'(p), "R7 hold without edges", pre_q, p);
    aux_clk = 1'b1;
    wait_n(6);
    chk(pre_q == 3'd0, "R8 first high clears", pre_q, 0);
    aux_clk = 1'b0;
    wait_n(6);
    aux_clk = 1'b1;
    wait_n(6);
    chk(pre_q == 3'd1, "R8 next edge counts", pre_q, 1);
    aux_clk = 1'b0;
    wait_n(4);
    aux_run = 1'b1;
    pulse_clear();
    expect_wave(64, 32, "R7 aux clocked 9600");
    aux_run = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule